// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block sits beside a small CPU core and decides which of five interrupt sources the core should serve next. Each source can be masked on its own. A global gate masks all of them at once. A priority bit places each source at either the high level or the low level. When more than one request is eligible, the block presents a single winner to the core together with that winner's vector address.

The core signals with a take strobe when it begins a service routine. The block then marks the routine's level as in service and returns a one-cycle acknowledge, one-hot by source, so that the source can drop its request flag. The core signals with a return strobe when a routine ends. Two in-service flags, one for each level, decide whether a new request may preempt the running routine. Only a high-level request may preempt, and only when a low-level routine is running. Stacking of the program counter and saving of context are left to the core.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears the global gate, every source enable, every priority bit and both in-service flags. After reset, irq_o stays 0 whatever req_i holds.
- R2: A write with cfg_sel_i=0 loads the mask register, in which cfg_wdata_i[7] is the global gate. While the gate is 0, irq_o is 0 even for requests that are enabled.
- R3: In the mask register, cfg_wdata_i[4:0] are the per-source enables, with bit n belonging to source index n. A request on a disabled source never drives irq_o.
- R4: A write with cfg_sel_i=1 loads the priority bits from cfg_wdata_i[4:0], indexed by source (1 = high level). When no routine is in service, an eligible high-level request wins over any low-level request.
- R5: Source indices are 0 = external 0, 1 = external 1, 2 = timer 0, 3 = timer 1, 4 = serial. Within one level the winner follows the order external 0, timer 0, external 1, timer 1, serial. irq_vec_o is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for these ranks in turn.
- R6: take_i while irq_o is 1 sets the in-service flag of the winner's level. In the next cycle, and only for that one cycle, ack_o carries the winner as a one-hot value at its source index.
- R7: While only the low flag is set, low-level requests are blocked and high-level requests still reach irq_o.
- R8: While the high flag is set, irq_o is 0 for every request.
- R9: return_i clears the high flag when it is set, and otherwise clears the low flag.
- R10: take_i while irq_o is 0 changes no flag and produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = mask register, 1 = priority register |
| cfg_wdata_i | input | 8 | Write data |
| req_i | input | 5 | Request lines by source index |
| take_i | input | 1 | Core enters the presented service routine |
| return_i | input | 1 | Core leaves the current service routine |
| irq_o | output | 1 | An eligible request is presented |
| irq_vec_o | output | 16 | Vector address of the presented request |
| ack_o | output | 5 | One-cycle one-hot acknowledge by source index |

## Verification
A corrupted in-service flag becomes visible at the ports in the same cycle. A stuck high flag holds irq_o low against every request. A lost low flag lets a second low-level request through while a low routine is running. A return strobe that clears the wrong flag shows up on the first request after that return, either as a request that stays hidden or as one that wrongly appears. A fault in the order or the vector table shows on irq_vec_o as soon as two requests of one level are pending together. A fault in the acknowledge path shows in the cycle that follows a take.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC    = 5;
    localparam int SRC_W   = $clog2(NSRC);
    localparam int RANK_W  = $clog2(NSRC);
    localparam int CFG_W   = 8;
    localparam int GATE_BIT = 7;
    localparam int VEC_W   = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_EXT1 = 3'd1,
        SRC_TMR0 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef struct packed {
        logic            gate;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] hi;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic              level_hi;
        logic [RANK_W-1:0] rank;
        logic [NSRC-1:0]   onehot;
    } grant_t;

    // Fixed service order: rank 0 is served first within a level.
    function automatic logic [SRC_W-1:0] rank_src(input int rank);
        case (rank)
            0:       rank_src = SRC_EXT0;
            1:       rank_src = SRC_TMR0;
            2:       rank_src = SRC_EXT1;
            3:       rank_src = SRC_TMR1;
            default: rank_src = SRC_SER;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] rank_vec(input logic [RANK_W-1:0] rank);
        rank_vec = VEC_W'(VEC_BASE) + VEC_W'(rank) * VEC_W'(VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_nest_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            if (sel) begin
                cfg_q.hi <= wdata[NSRC-1:0];
            end else begin
                cfg_q.gate <= wdata[GATE_BIT];
                cfg_q.en   <= wdata[NSRC-1:0];
            end
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_nest_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [NSRC-1:0]  req,
    input  logic             ins_hi,
    input  logic             ins_lo,
    output grant_t           gnt,
    output logic [VEC_W-1:0] vec
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] hi_c;
    logic [NSRC-1:0] lo_c;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] ord;

    assign pend = req & cfg.en & {NSRC{cfg.gate}};
    assign hi_c = pend & cfg.hi;
    assign lo_c = pend & ~cfg.hi;

    // Level gating by the in-service state.
    always_comb begin
        if (ins_hi)        elig = '0;
        else if (ins_lo)   elig = hi_c;
        else if (|hi_c)    elig = hi_c;
        else               elig = lo_c;
    end

    // Reorder eligible requests into service rank order.
    for (genvar r = 0; r < NSRC; r++) begin : g_ord
        assign ord[r] = elig[rank_src(r)];
    end

    always_comb begin
        gnt = '0;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (ord[r]) begin
                gnt.valid = 1'b1;
                gnt.rank  = RANK_W'(r);
            end
        end
        if (gnt.valid) begin
            gnt.onehot = NSRC'(1) << rank_src(int'(gnt.rank));
        end
        gnt.level_hi = |(gnt.onehot & cfg.hi);
    end

    assign vec = gnt.valid ? rank_vec(gnt.rank) : '0;
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
    input  logic clk,
    input  logic rst,
    input  logic take_ok,
    input  logic take_hi,
    input  logic ret,
    output logic ins_hi,
    output logic ins_lo
);
    logic hi_q, lo_q, hi_n, lo_n;

    always_comb begin
        hi_n = hi_q;
        lo_n = lo_q;
        if (ret) begin
            if (hi_q) hi_n = 1'b0;
            else      lo_n = 1'b0;
        end
        if (take_ok) begin
            if (take_hi) hi_n = 1'b1;
            else         lo_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign ins_hi = hi_q;
    assign ins_lo = lo_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic [NSRC-1:0]  req_i,
    input  logic             take_i,
    input  logic             return_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o,
    output logic [NSRC-1:0]  ack_o
);
    cfg_t            cfg_q;
    grant_t          gnt;
    logic            ins_hi, ins_lo;
    logic            take_ok;
    logic [NSRC-1:0] ack_q;

    irq_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we_i),
        .sel   (cfg_sel_i),
        .wdata (cfg_wdata_i),
        .cfg   (cfg_q)
    );

    irq_arbiter u_arb (
        .cfg    (cfg_q),
        .req    (req_i),
        .ins_hi (ins_hi),
        .ins_lo (ins_lo),
        .gnt    (gnt),
        .vec    (irq_vec_o)
    );

    assign take_ok = take_i & gnt.valid;

    irq_inservice u_ins (
        .clk     (clk),
        .rst     (rst),
        .take_ok (take_ok),
        .take_hi (gnt.level_hi),
        .ret     (return_i),
        .ins_hi  (ins_hi),
        .ins_lo  (ins_lo)
    );

    always_ff @(posedge clk) begin
        if (rst)          ack_q <= '0;
        else if (take_ok) ack_q <= gnt.onehot;
        else              ack_q <= '0;
    end

    assign irq_o = gnt.valid;
    assign ack_o = ack_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
    import irq_nest_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             take,
    input logic             ret,
    input logic             irq,
    input logic [VEC_W-1:0] vec,
    input logic [NSRC-1:0]  ack,
    input logic             ins_hi,
    input logic             ins_lo,
    input logic [NSRC-1:0]  prio_hi,
    input logic [NSRC-1:0]  win
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq && !ins_hi && !ins_lo && ack == '0));

    assert_vec_grid_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (vec[2:0] == 3'b011 && vec <= VEC_W'(16'h0023)));

    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));

    assert_ack_after_take_R6: assert property (@(posedge clk) disable iff (rst)
        (take && irq) |=> (ack != '0));

    assert_lo_preempt_only_hi_R7: assert property (@(posedge clk) disable iff (rst)
        (ins_lo && irq) |-> ((win & prio_hi) != '0));

    assert_hi_blocks_all_R8: assert property (@(posedge clk) disable iff (rst)
        ins_hi |-> !irq);

    assert_ret_hi_first_R9: assert property (@(posedge clk) disable iff (rst)
        (ret && ins_hi && !(take && irq)) |=> (!ins_hi && ins_lo == $past(ins_lo)));

    assert_idle_take_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(take && irq) |=> (ack == '0));
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .take    (take_i),
    .ret     (return_i),
    .irq     (irq_o),
    .vec     (irq_vec_o),
    .ack     (ack_o),
    .ins_hi  (ins_hi),
    .ins_lo  (ins_lo),
    .prio_hi (cfg_q.hi),
    .win     (gnt.onehot)
);

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic [4:0]  req_i = '0;
    logic        take_i = 1'b0;
    logic        return_i = 1'b0;
    logic        irq_o;
    logic [15:0] irq_vec_o;
    logic [4:0]  ack_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .req_i(req_i), .take_i(take_i),
        .return_i(return_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o), .ack_o(ack_o)
    );

    // Vector expected for a source index, from the service order in R5.
    function automatic logic [15:0] exp_vec(input int idx);
        case (idx)
            0: exp_vec = 16'h0003;
            2: exp_vec = 16'h000B;
            1: exp_vec = 16'h0013;
            3: exp_vec = 16'h001B;
            default: exp_vec = 16'h0023;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        req_i = '0; take_i = 0; return_i = 0; cfg_we_i = 0;
        rst = 1;
        cyc();
        rst = 0;
        #1;
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
        cyc();
        cfg_we_i = 0;
        #1;
    endtask

    task automatic do_take();
        take_i = 1;
        cyc();
        take_i = 0;
        #1;
    endtask

    task automatic do_ret();
        return_i = 1;
        cyc();
        return_i = 0;
        #1;
    endtask

    task automatic expect_irq(input string rq, input bit e_irq, input logic [15:0] e_vec);
        check(irq_o == e_irq, rq, irq_o, e_irq);
        if (e_irq) check(irq_vec_o == e_vec, rq, irq_vec_o, e_vec);
    endtask

    task automatic t_reset();
        do_reset();
        req_i = 5'h1F;
        #1;
        expect_irq("R1 reset masks", 0, 0);
        check(ack_o == 0, "R1 ack after reset", ack_o, 0);
        cyc();
        expect_irq("R1 still masked", 0, 0);
    endtask

    task automatic t_gate();
        do_reset();
        wr(0, 8'h1F);
        req_i = 5'h1F;
        #1;
        expect_irq("R2 gate off", 0, 0);
        wr(0, 8'h9F);
        expect_irq("R2 gate on", 1, exp_vec(0));
        wr(0, 8'h1F);
        expect_irq("R2 gate off again", 0, 0);
    endtask

    task automatic t_enable();
        do_reset();
        wr(0, 8'h81);
        req_i = 5'b00010;
        #1;
        expect_irq("R3 disabled source", 0, 0);
        wr(0, 8'h82);
        expect_irq("R3 enabled source", 1, exp_vec(1));
    endtask

    task automatic t_order();
        logic [4:0] r;
        do_reset();
        wr(0, 8'h9F);
        r = 5'h1F;
        req_i = r; #1;
        expect_irq("R5 all pending", 1, 16'h0003);
        r[0] = 0; req_i = r; #1;
        expect_irq("R5 timer0 next", 1, 16'h000B);
        r[2] = 0; req_i = r; #1;
        expect_irq("R5 ext1 next", 1, 16'h0013);
        r[1] = 0; req_i = r; #1;
        expect_irq("R5 timer1 next", 1, 16'h001B);
        r[3] = 0; req_i = r; #1;
        expect_irq("R5 serial last", 1, 16'h0023);
        req_i = 5'b01010; #1;
        expect_irq("R5 ext1 over timer1", 1, 16'h0013);
    endtask

    task automatic t_prio();
        do_reset();
        wr(0, 8'h9F);
        wr(1, 8'h10);
        req_i = 5'h1F; #1;
        expect_irq("R4 high serial wins", 1, 16'h0023);
        wr(1, 8'h18);
        expect_irq("R4 order among high", 1, 16'h001B);
    endtask

    task automatic t_nest();
        do_reset();
        wr(0, 8'h9F);
        wr(1, 8'h10);
        req_i = 5'b00001; #1;
        expect_irq("R6 low ext0 offered", 1, 16'h0003);
        do_take();
        check(ack_o == 5'b00001, "R6 ack ext0", ack_o, 5'b00001);
        req_i = 5'b00100;
        cyc();
        check(ack_o == 0, "R6 ack one cycle", ack_o, 0);
        expect_irq("R7 low blocked by low", 0, 0);
        req_i = 5'b10100; #1;
        expect_irq("R7 high preempts", 1, 16'h0023);
        do_take();
        check(ack_o == 5'b10000, "R6 ack serial", ack_o, 5'b10000);
        expect_irq("R8 high blocks high", 0, 0);
        req_i = 5'b10101; #1;
        expect_irq("R8 high blocks all", 0, 0);
        req_i = 5'b00101;
        do_ret();
        expect_irq("R9 low still in service", 0, 0);
        do_ret();
        expect_irq("R9 low cleared", 1, 16'h0003);
    endtask

    task automatic t_idle_take();
        do_reset();
        wr(0, 8'h9F);
        do_take();
        check(ack_o == 0, "R10 no ack when idle", ack_o, 0);
        req_i = 5'b00010; #1;
        expect_irq("R10 no flag set", 1, 16'h0013);
        wr(0, 8'h00);
        do_take();
        check(ack_o == 0, "R10 no ack when masked", ack_o, 0);
        wr(0, 8'h9F);
        expect_irq("R10 still free", 1, 16'h0013);
    endtask

    initial begin
        t_reset();
        t_gate();
        t_enable();
        t_order();
        t_prio();
        t_nest();
        t_idle_take();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule